// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a bus master for the two-wire PHY management interface. Software writes one 32-bit command word. The word holds the start code, the opcode, the turnaround bits, the PHY address, the register address and, for a write, 16 data bits. The block then shifts out a complete clause-22 management frame on MDC and MDIO. Every frame begins with a full 32-bit preamble of ones.

When the frame ends, a completion flag is set in an event register, and software clears that flag by writing a one to it. For a read, the 16 bits returned by the PHY replace the low half of the command register, so the same register is both the launch word and the result. A divider register sets the MDC rate. MDC runs at the system clock divided by twice the programmed field value, and a field of zero stops MDC and prevents any frame from starting.

Registers are selected by a 2-bit word address. Offset 0 is the event register, offset 1 is the command/data register, offset 2 is the divider and offset 3 is status.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: A write to offset 1 while idle, with a non-zero divider, starts a frame. The busy flag (offset 3, bit 0) reads 1 until the frame ends.
- R2: A frame is 32 ones followed by the 32 command bits, bit 31 first. The command bits are: [31:30] start code, [29:28] opcode (10 read, 01 write), [27:23] PHY address, [22:18] register address, [17:16] turnaround, [15:0] data. Each bit is presented while MDC is low and holds across the rising MDC edge.
- R3: The divider field sits in offset 2 bits [DIV_W:1]. Consecutive MDC rising edges are 2×field system clocks apart, and MDC is low whenever no frame runs.
- R4: For a read (opcode 10), the MDIO output enable drops from the first turnaround bit (frame bit 46) to the end of the frame. For a write it stays asserted for all 64 bits.
- R5: For a read, MDIO is sampled at the 16 MDC rising edges after the turnaround. The result lands in offset 1 bits [15:0], MSB first, and bits [31:16] are unchanged.
- R6: When the last bit ends, busy clears and event bit 0 (offset 0) sets in the same cycle.
- R7: Writing 1 to event bit 0 clears it. Writing 0 leaves it set.
- R8: A command written while busy is ignored: the register contents and the running frame are unchanged.
- R9: With a divider field of zero, MDC stays low and a command write neither starts a frame nor loads the register.
- R10: After reset every register reads zero, MDC is low and the MDIO output enable is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The bench builds the block with the default DIV_W of 6. It programs divider fields of 2, 3 and 1, so that full 64-bit frames stay short and MDC periods of 4, 6 and 2 clocks can all be measured. A field of 1 exercises the fastest toggle, where every clock cycle ends a half period. The zero field, present straight out of reset, exercises the hold-off path.

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl #(
  parameter int DIV_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam logic [5:0] TA_POS  = 6'd46;
  localparam logic [5:0] DAT_POS = 6'd48;
  localparam logic [5:0] END_POS = 6'd63;
  localparam logic [1:0] A_EVT = 2'd0, A_CMD = 2'd1, A_DIV = 2'd2, A_STAT = 2'd3;
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic             busy, is_rd, done_evt;
  logic [5:0]       bitn;
  logic [DIV_W-1:0] div_q, cnt;
  logic [31:0]      cmd_q;

  wire run      = busy && (div_q != '0);
  wire tick     = run && (cnt >= div_q - ONE);
  wire start    = wr_en && (addr == A_CMD) && !busy && (div_q != '0);
  wire rd_phase = is_rd && (bitn >= TA_POS);
  wire last_end = tick && mdc && (bitn == END_POS);

  assign mdio_oe = busy && !rd_phase;
  assign mdio_o  = busy && (!bitn[5] || cmd_q[~bitn[4:0]]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; is_rd <= 1'b0; done_evt <= 1'b0; mdc <= 1'b0;
      bitn <= '0; div_q <= '0; cnt <= '0; cmd_q <= '0;
    end else begin
      if (wr_en && addr == A_DIV) div_q <= wdata[DIV_W:1];
      if (start) begin
        cmd_q <= wdata;
        busy  <= 1'b1;
        is_rd <= (wdata[29:28] == 2'b10);
        bitn  <= '0;
        cnt   <= '0;
        mdc   <= 1'b0;
      end else if (run) begin
        if (tick) begin
          cnt <= '0;
          mdc <= !mdc;
          if (!mdc) begin
            if (rd_phase && bitn >= DAT_POS) cmd_q[15:0] <= {cmd_q[14:0], mdio_i};
          end else if (bitn == END_POS) begin
            busy <= 1'b0;
          end else begin
            bitn <= bitn + 6'd1;
          end
        end else begin
          cnt <= cnt + ONE;
        end
      end
      if (last_end) done_evt <= 1'b1;
      else if (wr_en && addr == A_EVT && wdata[0]) done_evt <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      A_EVT:   rdata = {31'b0, done_evt};
      A_CMD:   rdata = cmd_q;
      A_DIV:   rdata = {{(31-DIV_W){1'b0}}, div_q, 1'b0};
      A_STAT:  rdata = {31'b0, busy};
      default: rdata = '0;
    endcase
  end

  p_idle_mdc_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  p_rise_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy);
  p_end_sets_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_evt);
  p_event_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt && !(wr_en && addr == A_EVT && wdata[0]) |=> done_evt);
  p_busy_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en && addr == A_CMD |=> $stable(cmd_q[31:16]));
  p_div_zero_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && div_q == '0 |=> !busy);

endmodule

// File: tb/mdio_frame_ctrl_tb_top.sv
module mdio_frame_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, mdio_i;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic mdc, mdio_o, mdio_oe;

  int vectors = 0, miscompares = 0;
  bit exp_bit[$];
  bit exp_oe[$];
  int rise_idx = 0, cur_div = 1, since_rise = 0;
  bit first_rise = 1'b1, done_flag = 1'b0;
  logic [15:0] phy_word = 16'h0;

  always #5 clk = ~clk;

  mdio_frame_ctrl #(.DIV_W(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  assign mdio_i = (rise_idx >= 48 && rise_idx < 64) ? phy_word[63 - rise_idx] : 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic launch(input logic [31:0] word, input int div);
    bit read_op;
    read_op = (word[29:28] == 2'b10);
    rise_idx = 0; first_rise = 1'b1; cur_div = div;
    for (int i = 0; i < 32; i++) begin exp_bit.push_back(1'b1); exp_oe.push_back(1'b1); end
    for (int i = 31; i >= 0; i--) begin
      exp_bit.push_back(word[i]);
      exp_oe.push_back(!(read_op && i <= 17));
    end
    wr(2'd1, word);
  endtask

  task automatic wait_idle;
    logic [31:0] s;
    s = 32'd1;
    for (int n = 0; n < 5000 && s[0]; n++) rd(2'd3, s);
  endtask

  initial begin : monitor
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      since_rise++;
      if (mdc && !prev) begin
        if (exp_oe.size() == 0) chk("R2 unexpected MDC rise", 32'd1, 32'd0);
        else begin
          bit eb, eo;
          eb = exp_bit.pop_front();
          eo = exp_oe.pop_front();
          chk("R4 output enable", {31'b0, mdio_oe}, {31'b0, eo});
          if (eo) chk("R2 frame bit", {31'b0, mdio_o}, {31'b0, eb});
        end
        if (!first_rise) chk("R3 MDC period", since_rise, 2 * cur_div);
        first_rise = 1'b0;
        since_rise = 0;
        rise_idx++;
      end
      prev = mdc;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : driver
    logic [31:0] d, w1, w2;
    w1 = {2'b01, 2'b01, 5'h05, 5'h12, 2'b10, 16'hA5C3};
    w2 = {2'b01, 2'b10, 5'h1F, 5'h01, 2'b11, 16'h0000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 4; a++) begin rd(2'(a), d); chk("R10 reset register", d, 32'h0); end
    chk("R10 reset mdc", {31'b0, mdc}, 32'h0);
    chk("R10 reset oe", {31'b0, mdio_oe}, 32'h0);

    wr(2'd1, w1);
    rd(2'd3, d); chk("R9 no start with zero divider", d, 32'h0);
    rd(2'd1, d); chk("R9 register not loaded", d, 32'h0);
    for (int i = 0; i < 20; i++) begin @(negedge clk); chk("R9 mdc held low", {31'b0, mdc}, 32'h0); end

    wr(2'd2, 32'h4);
    rd(2'd2, d); chk("R3 divider readback", d, 32'h4);

    launch(w1, 2);
    rd(2'd3, d); chk("R1 busy after launch", d, 32'h1);
    repeat (30) @(negedge clk);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R8 command ignored while busy", d, w1);
    wait_idle();
    chk("R2 all write bits seen", exp_oe.size(), 0);
    rd(2'd0, d); chk("R6 event set", d, 32'h1);
    chk("R3 mdc low when idle", {31'b0, mdc}, 32'h0);
    chk("R4 oe off when idle", {31'b0, mdio_oe}, 32'h0);
    rd(2'd1, d); chk("R5 write keeps register", d, w1);

    wr(2'd0, 32'h0);
    rd(2'd0, d); chk("R7 writing zero keeps event", d, 32'h1);
    wr(2'd0, 32'h1);
    rd(2'd0, d); chk("R7 writing one clears event", d, 32'h0);

    wr(2'd2, 32'h6);
    phy_word = 16'h9B6E;
    launch(w2, 3);
    wait_idle();
    chk("R4 all read bits seen", exp_oe.size(), 0);
    rd(2'd1, d); chk("R5 read data captured", d, {w2[31:16], 16'h9B6E});
    rd(2'd0, d); chk("R6 event after read", d, 32'h1);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk("R7 all-ones clears event", d, 32'h0);

    wr(2'd2, 32'h2);
    phy_word = 16'h0;
    launch(32'h5FFF_0001, 1);
    wait_idle();
    chk("R2 fastest divider frame done", exp_oe.size(), 0);
    rd(2'd1, d); chk("R1 final register value", d, 32'h5FFF_0001);

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule